// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block takes one ARINC 429 channel after the analog front end has reduced it to two logic indications, one for a positive (ONE) line state and one for a negative (ZERO) line state, with both low meaning NULL. It samples the return-to-zero stream at about ten samples per bit, times every high pulse and every null, and shifts the bits into a 32-bit word, first bit received first. When three bit-times of NULL close a word, the block decides whether to keep it. A word is kept only if it has exactly 32 bits, has no timing or level fault, and passes the optional label-bit filter.

A kept word replaces the held word and raises a data-ready flag. In the held word, bit 32 is replaced by the result of the parity check. The host reads the word as two 16-bit halves through a read enable and a half-select input. Reading the second half clears the flag.

The sample clock comes from the 1 MHz master clock. It is either the master clock itself or the master clock divided by eight, so one design serves both ARINC speeds.

Top module: `a429_word_rx`

## Requirements
- R1: With `cfg_slow`=0 the line is sampled on every master clock. With `cfg_slow`=1 it is sampled on every eighth master clock. A word timed for one setting is rejected under the other.
- R2: A high pulse (a run of ONE samples or of ZERO samples) must last 3 to 7 samples. From the start of one pulse to the start of the next, the bit period must be 8 to 12 samples. Otherwise the word is rejected.
- R3: A null of fewer than 3 samples between two bits rejects the word. So does a direct change from ONE to ZERO, or from ZERO to ONE, without a null.
- R4: A sample with both `line_one` and `line_zero` high is invalid. It rejects the word it falls in, whether it falls in a pulse or in a null.
- R5: A word ends after 30 consecutive NULL samples. Only words of exactly 32 bits are accepted; 31-bit and 33-bit words are dropped.
- R6: With `cfg_filt_en`=1, a word is accepted only if ARINC bit 9 equals `cfg_lbl9` and ARINC bit 10 equals `cfg_lbl10`. With `cfg_filt_en`=0 these two bits have no effect on acceptance.
- R7: The held bit 32 is a parity status. It is 1 when the 32 received bits contain an odd number of ones, and 0 otherwise.
- R8: With `half_sel`=0, `rd_data` carries the following, most significant bit first: bits 13, 12, 11, 10, 9, then bit 31, bit 30, the parity status, then bits 1 to 8 (bit 1 on `rd_data[7]`, bit 8 on `rd_data[0]`).
- R9: With `half_sel`=1, `rd_data[15:0]` carries ARINC bits 29 down to 14.
- R10: `rd_data` is all zeros whenever `rd_en` is low.
- R11: `data_ready` rises after a word is accepted. It clears on the clock edge where `rd_en`=1 and `half_sel`=1. A word accepted at that same edge wins, and the flag stays set. A new word accepted before the read overwrites the held word.
- R12: After reset, `data_ready` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1 MHz master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_one | input | 1 | Line is in the ONE state |
| line_zero | input | 1 | Line is in the ZERO state |
| cfg_slow | input | 1 | 0: sample every clock, 1: every eighth clock |
| cfg_filt_en | input | 1 | Enables the bit 9/10 filter |
| cfg_lbl9 | input | 1 | Required value of ARINC bit 9 |
| cfg_lbl10 | input | 1 | Required value of ARINC bit 10 |
| rd_en | input | 1 | Read enable; drives the read bus |
| half_sel | input | 1 | 0: first half, 1: second half |
| data_ready | output | 1 | A held word is waiting to be read |
| rd_data | output | 16 | Selected half of the held word |

## Verification
Two events can fall on the same clock edge: a new word being accepted, and the host finishing its read of the second half. The bench sends a word whose closing null is exactly 30 samples long. It raises the second-half read in the cycle right after the last of those samples is taken, so the acceptance and the read land on one edge. The bench then expects `data_ready` still set and the new word on the bus. One edge later, with the read still held, it expects the flag to clear.

// File: rtl/a429rx_pkg.sv
package a429rx_pkg;

  localparam int WORD_BITS = 32;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_HIGH = 2'd1,
    FR_NULL = 2'd2
  } fr_state_t;

  // 1 when the word holds an odd number of ones
  function automatic logic odd_ones(input logic [WORD_BITS-1:0] w);
    return ^w;
  endfunction

  // Bus view of a held word; index k-1 holds ARINC bit k
  function automatic logic [15:0] half_view(input logic [WORD_BITS-1:0] w,
                                            input logic sel);
    logic [15:0] h;
    if (sel) h = w[28:13];
    else     h = {w[12], w[11], w[10], w[9], w[8], w[30], w[29], w[31],
                  w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7]};
    return h;
  endfunction

  // Label-bit filter on ARINC bits 9 and 10
  function automatic logic lbl_pass(input logic [WORD_BITS-1:0] w,
                                    input logic en, input logic b9,
                                    input logic b10);
    return !en || ((w[8] == b9) && (w[9] == b10));
  endfunction

endpackage

// File: rtl/a429rx_tick.sv
module a429rx_tick #(
  parameter int SLOW_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  output logic tick
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = slow ? (cnt == LAST) : 1'b1;

  // R1: in slow mode two sample ticks never sit on adjacent clocks
  p_slow_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (slow && $past(slow) && tick) |=> !tick);

endmodule

// File: rtl/a429rx_framer.sv
module a429rx_framer
  import a429rx_pkg::*;
#(
  parameter int HI_MIN   = 3,
  parameter int HI_MAX   = 7,
  parameter int NULL_MIN = 3,
  parameter int PER_MIN  = 8,
  parameter int PER_MAX  = 12,
  parameter int GAP_LEN  = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 one_i,
  input  logic                 zero_i,
  input  logic                 filt_en,
  input  logic                 lbl9,
  input  logic                 lbl10,
  output logic                 word_ok,
  output logic [WORD_BITS-1:0] word_q
);
  localparam int RUN_W  = $clog2(GAP_LEN + 1);
  localparam int BCNT_W = $clog2(WORD_BITS + 2);
  localparam logic [RUN_W-1:0]  RUN_TOP  = '1;
  localparam logic [BCNT_W-1:0] BCNT_TOP = BCNT_W'(WORD_BITS + 1);
  localparam logic [BCNT_W-1:0] BCNT_OK  = BCNT_W'(WORD_BITS);

  fr_state_t             st;
  logic [RUN_W-1:0]      run, hi_len;
  logic [BCNT_W-1:0]     bcnt;
  logic [WORD_BITS-1:0]  sr;
  logic                  cur, err;

  // named events for readability and assertions
  logic is_null, is_bad, gap_done;
  assign is_null  = !one_i && !zero_i;
  assign is_bad   = one_i && zero_i;
  assign gap_done = tick && !is_bad && is_null && (st == FR_NULL) &&
                    (run == RUN_W'(GAP_LEN - 1));

  function automatic logic [RUN_W-1:0] bump(input logic [RUN_W-1:0] r);
    return (r == RUN_TOP) ? r : r + 1'b1;
  endfunction

  function automatic logic pulse_ok(input logic [RUN_W-1:0] h);
    return (int'(h) >= HI_MIN) && (int'(h) <= HI_MAX);
  endfunction

  function automatic logic spacing_ok(input logic [RUN_W-1:0] h,
                                      input logic [RUN_W-1:0] n);
    int per;
    per = int'(h) + int'(n);
    return (int'(n) >= NULL_MIN) && (per >= PER_MIN) && (per <= PER_MAX);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= FR_IDLE;
      run     <= '0;
      hi_len  <= '0;
      bcnt    <= '0;
      sr      <= '0;
      cur     <= 1'b0;
      err     <= 1'b0;
      word_ok <= 1'b0;
      word_q  <= '0;
    end else begin
      word_ok <= 1'b0;
      if (tick) begin
        if (is_bad) begin
          err <= 1'b1;
          st  <= FR_NULL;
          run <= RUN_W'(1);
          if (st == FR_IDLE) bcnt <= '0;
        end else begin
          unique case (st)
            FR_IDLE: if (!is_null) begin
              st   <= FR_HIGH;
              run  <= RUN_W'(1);
              cur  <= one_i;
              bcnt <= '0;
              err  <= 1'b0;
            end
            FR_HIGH: begin
              if (is_null) begin
                if (!pulse_ok(run)) err <= 1'b1;
                hi_len <= run;
                sr     <= {cur, sr[WORD_BITS-1:1]};
                bcnt   <= (bcnt == BCNT_TOP) ? bcnt : bcnt + 1'b1;
                st     <= FR_NULL;
                run    <= RUN_W'(1);
              end else begin
                if (one_i != cur) err <= 1'b1;
                cur <= one_i;
                run <= bump(run);
              end
            end
            FR_NULL: begin
              if (is_null) begin
                if (gap_done) begin
                  word_ok <= !err && (bcnt == BCNT_OK) &&
                             lbl_pass(sr, filt_en, lbl9, lbl10);
                  word_q  <= {odd_ones(sr), sr[WORD_BITS-2:0]};
                  st      <= FR_IDLE;
                  run     <= '0;
                end else begin
                  run <= bump(run);
                end
              end else begin
                if (!spacing_ok(hi_len, run)) err <= 1'b1;
                st  <= FR_HIGH;
                run <= RUN_W'(1);
                cur <= one_i;
              end
            end
            default: st <= FR_IDLE;
          endcase
        end
      end
    end
  end

  // R5: an accepted word always carried exactly WORD_BITS bits
  p_ok_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok |-> ($past(bcnt) == BCNT_OK));
  // R5: acceptance is a single-cycle pulse
  p_ok_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok |=> !word_ok);
  // R6: with the filter on, accepted bits 9 and 10 match the compare values
  p_ok_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && $past(filt_en)) |->
      (word_q[8] == $past(lbl9)) && (word_q[9] == $past(lbl10)));

endmodule

// File: rtl/a429rx_hold.sv
module a429rx_hold
  import a429rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_ok,
  input  logic [WORD_BITS-1:0] word_q,
  input  logic                 rd_en,
  input  logic                 half_sel,
  output logic                 data_ready,
  output logic [15:0]          rd_data
);
  logic [WORD_BITS-1:0] held;
  logic                 last_read;

  assign last_read = rd_en && half_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held       <= '0;
      data_ready <= 1'b0;
    end else if (word_ok) begin
      held       <= word_q;
      data_ready <= 1'b1;
    end else if (last_read) begin
      data_ready <= 1'b0;
    end
  end

  assign rd_data = rd_en ? half_view(held, half_sel) : 16'h0000;

  // R11: acceptance raises the flag on the next cycle
  p_ready_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok |=> data_ready);
  // R11: a second-half read without a colliding word clears the flag
  p_ready_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && last_read && !word_ok) |=> !data_ready);
  // R11: the held word only moves on acceptance
  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !word_ok |=> $stable(held));

endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx
  import a429rx_pkg::*;
#(
  parameter int SLOW_DIV = 8,
  parameter int HI_MIN   = 3,
  parameter int HI_MAX   = 7,
  parameter int NULL_MIN = 3,
  parameter int PER_MIN  = 8,
  parameter int PER_MAX  = 12,
  parameter int GAP_LEN  = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_one,
  input  logic        line_zero,
  input  logic        cfg_slow,
  input  logic        cfg_filt_en,
  input  logic        cfg_lbl9,
  input  logic        cfg_lbl10,
  input  logic        rd_en,
  input  logic        half_sel,
  output logic        data_ready,
  output logic [15:0] rd_data
);
  logic                 samp_tick;
  logic                 word_ok;
  logic [WORD_BITS-1:0] word_q;

  a429rx_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .slow(cfg_slow), .tick(samp_tick)
  );

  a429rx_framer #(
    .HI_MIN(HI_MIN), .HI_MAX(HI_MAX), .NULL_MIN(NULL_MIN),
    .PER_MIN(PER_MIN), .PER_MAX(PER_MAX), .GAP_LEN(GAP_LEN)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(samp_tick),
    .one_i(line_one), .zero_i(line_zero),
    .filt_en(cfg_filt_en), .lbl9(cfg_lbl9), .lbl10(cfg_lbl10),
    .word_ok(word_ok), .word_q(word_q)
  );

  a429rx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .word_ok(word_ok), .word_q(word_q),
    .rd_en(rd_en), .half_sel(half_sel),
    .data_ready(data_ready), .rd_data(rd_data)
  );

endmodule

// File: tb/tb_a429_word_rx.sv
`timescale 1ns/1ps
module tb_a429_word_rx;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_one = 1'b0, line_zero = 1'b0;
  logic cfg_slow = 1'b0, cfg_filt_en = 1'b0, cfg_lbl9 = 1'b0, cfg_lbl10 = 1'b0;
  logic rd_en = 1'b0, half_sel = 1'b0;
  logic data_ready;
  logic [15:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  a429_word_rx dut (.*);

  typedef struct packed {
    logic [31:0] w;
    logic [3:0]  hi;
    logic [3:0]  nu;
    logic [3:0]  hold;
    logic [5:0]  nbits;
    logic [1:0]  fault;  // 1 bad null sample, 2 no null, 3 bad pulse sample
    logic        slow;
    logic        fen;
    logic        f9;
    logic        f10;
    logic        ok;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{32'h1234_5678, 4'd5, 4'd5, 4'd1, 6'd32, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 R8 R9
    '{32'hFFFF_FFFF, 4'd5, 4'd5, 4'd1, 6'd32, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 even
    '{32'h0000_0001, 4'd5, 4'd5, 4'd1, 6'd32, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 odd
    '{32'hA5A5_0F0F, 4'd4, 4'd4, 4'd1, 6'd32, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 period 8
    '{32'h5A5A_F0F0, 4'd6, 4'd6, 4'd1, 6'd32, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 period 12
    '{32'h1357_9BDF, 4'd5, 4'd9, 4'd1, 6'd32, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 period 14
    '{32'h1357_9BDF, 4'd2, 4'd6, 4'd1, 6'd32, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 short pulse
    '{32'h1357_9BDF, 4'd8, 4'd3, 4'd1, 6'd32, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 long pulse
    '{32'h1357_9BDF, 4'd7, 4'd2, 4'd1, 6'd32, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 short null
    '{32'h1357_9BDF, 4'd5, 4'd5, 4'd1, 6'd31, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 31 bits
    '{32'h1357_9BDF, 4'd5, 4'd5, 4'd1, 6'd33, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 33 bits
    '{32'h1357_9BDF, 4'd5, 4'd5, 4'd1, 6'd32, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 in null
    '{32'h1357_9BDF, 4'd5, 4'd5, 4'd1, 6'd32, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 in pulse
    '{32'h1357_9BDF, 4'd5, 4'd5, 4'd1, 6'd32, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 no null
    '{32'h0000_0300, 4'd5, 4'd5, 4'd1, 6'd32, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 match
    '{32'h0000_0100, 4'd5, 4'd5, 4'd1, 6'd32, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 mismatch
    '{32'h0000_0100, 4'd5, 4'd5, 4'd1, 6'd32, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 ignored
    '{32'hC0DE_1234, 4'd5, 4'd5, 4'd8, 6'd32, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1},  // R1 slow ok
    '{32'hC0DE_1234, 4'd5, 4'd5, 4'd8, 6'd32, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1}   // R1 fast rejects
  };

  // expected bus halves, built from ARINC bit numbers
  function automatic logic [15:0] exp_half(input logic [31:0] w, input logic sel);
    logic [32:1] a;
    logic [15:0] h;
    int ones;
    ones = 0;
    for (int n = 1; n <= 32; n++) begin
      a[n] = w[n-1];
      ones += int'(w[n-1]);
    end
    a[32] = (ones % 2 == 1);
    h = '0;
    if (sel) begin
      for (int n = 14; n <= 29; n++) h[n-14] = a[n];
    end else begin
      for (int n = 1; n <= 8; n++) h[8-n] = a[n];
      for (int n = 9; n <= 13; n++) h[n+2] = a[n];
      h[8] = a[32]; h[9] = a[30]; h[10] = a[31];
    end
    return h;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] p, input int hold);
    {line_one, line_zero} = p;
    repeat (hold) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w, input int hi, input int nu,
                           input int hold, input int nbits, input int fault,
                           input int tail);
    for (int b = 0; b < nbits; b++) begin
      logic v;
      v = (b < 32) ? w[b] : 1'b0;
      for (int s = 0; s < hi; s++)
        put((fault == 3 && b == 5 && s == 1) ? 2'b11 : (v ? 2'b10 : 2'b01), hold);
      if (b == nbits - 1) begin
        for (int s = 0; s < tail; s++) put(2'b00, hold);
      end else begin
        for (int s = 0; s < nu; s++)
          put((fault == 1 && b == 5 && s == 0) ? 2'b11 :
              (fault == 2 && b == 5) ? (v ? 2'b01 : 2'b10) : 2'b00, hold);
      end
    end
  endtask

  task automatic read_half(input logic sel, output logic [15:0] val);
    rd_en = 1'b1; half_sel = sel;
    #1 val = rd_data;
    @(negedge clk);
    rd_en = 1'b0; half_sel = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] h0, h1;
    repeat (4) @(negedge clk);
    // R12: reset state
    check(32'(data_ready), 0, "R12 ready after reset");
    rd_en = 1'b1; #1;
    check(32'(rd_data), 0, "R12 bus after reset");
    rd_en = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      cfg_slow = v.slow; cfg_filt_en = v.fen; cfg_lbl9 = v.f9; cfg_lbl10 = v.f10;
      repeat (16) @(negedge clk);
      send_word(v.w, int'(v.hi), int'(v.nu), int'(v.hold), int'(v.nbits),
                int'(v.fault), 34);
      repeat (3) @(negedge clk);
      check(32'(data_ready), 32'(v.ok), {tag, " ready"});
      if (v.ok) begin
        read_half(1'b0, h0);
        check(32'(h0), 32'(exp_half(v.w, 1'b0)), {tag, " R8 half0"});
        read_half(1'b1, h1);
        check(32'(h1), 32'(exp_half(v.w, 1'b1)), {tag, " R9 half1"});
        check(32'(data_ready), 0, {tag, " R11 cleared by read"});
      end
    end

    // R10 / R11 directed: overwrite, bus quiet, collision
    cfg_slow = 1'b0; cfg_filt_en = 1'b0;
    send_word(32'h8765_4321, 5, 5, 1, 32, 0, 34);
    check(32'(data_ready), 1, "R11 first word ready");
    #1 check(32'(rd_data), 0, "R10 bus low without rd_en");
    send_word(32'h0F1E_2D3C, 5, 5, 1, 32, 0, 34);
    read_half(1'b0, h0);
    check(32'(h0), 32'(exp_half(32'h0F1E_2D3C, 1'b0)), "R11 overwrite half0");
    check(32'(data_ready), 1, "R11 half0 read keeps ready");
    send_word(32'h2468_ACE0, 5, 5, 1, 32, 0, 30);
    rd_en = 1'b1; half_sel = 1'b1;   // lands on the acceptance edge
    @(negedge clk);
    check(32'(data_ready), 1, "R11 collision keeps ready");
    #1 check(32'(rd_data), 32'(exp_half(32'h2468_ACE0, 1'b1)), "R11 collision new word");
    @(negedge clk);
    check(32'(data_ready), 0, "R11 later read clears");
    rd_en = 1'b0; half_sel = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule